// File: doc/BRIEF.md
# Two-Strobe Transmit Word FIFO

This block gathers 31-bit transmit words from a 16-bit parallel bus and keeps up to eight of them queued for a serial line transmitter. A word arrives in two halves, each taken on its own one-cycle strobe. The low-half strobe comes first and holds bits 15:0. The high-half strobe follows and supplies bits 30:16, which completes the word and writes it into the next free slot.

The serializer sees the oldest queued word on `word_o` and takes it with a one-cycle `pop_i` pulse. A count output and two flags describe the occupancy. `ready_o` is high when the queue is empty and `full_o` is high when all eight slots are used. Any load attempt made while the queue is full is dropped without side effects. An active-low asynchronous reset empties the queue and discards a half-loaded word.

Top module: `tx_word_fifo`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `count_o` is 0, `ready_o` is 1 and `full_o` is 0. Any low half captured before the reset is discarded.
- R2: A `ld_lo_i` pulse captures `bus_i[15:0]` as word bits 15:0 and marks a low half as pending. It does not change `count_o`.
- R3: A `ld_hi_i` pulse with a low half pending, and with the queue not full, writes the word {`bus_i[14:0]`, low half}. `bus_i[15]` is ignored on this strobe. `count_o` rises by one in the following cycle and the pending mark clears.
- R4: A `ld_hi_i` pulse with no low half pending is ignored, and `count_o` is unchanged.
- R5: `word_o` shows the oldest stored word while `count_o` is nonzero. Each `pop_i` pulse on a non-empty queue removes that word, so words leave in the order they were written.
- R6: The queue holds at most eight words. `full_o` is 1 exactly when `count_o` is 8.
- R7: While `full_o` is 1, `ld_lo_i` and `ld_hi_i` have no effect. No word is written, `count_o` is unchanged and the pending state is unchanged.
- R8: `ready_o` is 1 exactly when `count_o` is 0. `ready_o` and `full_o` are never both 1.
- R9: A `pop_i` pulse while the queue is empty is ignored.
- R10: A completing `ld_hi_i` and a `pop_i` in the same cycle, on a queue that is neither empty nor full, leave `count_o` unchanged. The popped word leaves and the new word joins at the tail.
- R11: A second `ld_lo_i` before `ld_hi_i` replaces the pending low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 16 | Parallel load bus |
| ld_lo_i | input | 1 | Low-half load strobe (bits 15:0) |
| ld_hi_i | input | 1 | High-half load strobe (bits 30:16 from bus bits 14:0) |
| pop_i | input | 1 | Take the oldest word, one-cycle pulse |
| word_o | output | 31 | Oldest stored word |
| count_o | output | 4 | Number of stored words, 0 to 8 |
| ready_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue holds eight words |

## Verification
The bound checker watches on every cycle that the count never passes eight and that the two flags are never high together. It also checks that a full queue holds its count when nothing is popped, that a pop moves the count down by one, that an empty queue ignores a pop, and that a lone low-half strobe leaves the count alone. The checker cannot see word content and ordering, the dropping of bus bit 15, or a pending low half that is replaced, discarded or lost at reset. The bench's scoreboard shows those by comparing every popped word with the word it expects.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  localparam int unsigned DEF_BUS_W  = 16;
  localparam int unsigned DEF_WORD_W = 31;
  localparam int unsigned DEF_DEPTH  = 8;

  typedef enum logic {
    HALF_IDLE = 1'b0,
    HALF_PEND = 1'b1
  } half_state_e;
endpackage

// File: rtl/tx_half_asm.sv
module tx_half_asm
  import tx_fifo_pkg::*;
#(
  parameter int unsigned BUS_W  = DEF_BUS_W,
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic              block_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned HI_W = WORD_W - BUS_W;

  half_state_e          state_q;
  logic [BUS_W-1:0]     lo_q;

  assign push_o = ld_hi_i && (state_q == HALF_PEND) && !block_i;
  assign word_o = {bus_i[HI_W-1:0], lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HALF_IDLE;
      lo_q    <= '0;
    end else if (!block_i) begin
      // a fresh low half wins over the completion in the same cycle
      if (ld_lo_i) begin
        state_q <= HALF_PEND;
        lo_q    <= bus_i;
      end else if (push_o) begin
        state_q <= HALF_IDLE;
      end
    end
  end
endmodule

// File: rtl/tx_fifo_ptrs.sv
module tx_fifo_ptrs #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL);
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/tx_word_mem.sv
module tx_word_mem #(
  parameter int unsigned WORD_W = 31,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_ptr_i == PTR_W'(i))) slot_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_ptr_i];
endmodule

// File: rtl/tx_word_fifo.sv
module tx_word_fifo
  import tx_fifo_pkg::*;
#(
  parameter int unsigned BUS_W  = DEF_BUS_W,
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              ready_o,
  output logic              full_o
);
  logic              push;
  logic [WORD_W-1:0] push_word;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              empty, full;

  tx_half_asm #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bus_i   (bus_i),
    .ld_lo_i (ld_lo_i),
    .ld_hi_i (ld_hi_i),
    .block_i (full),
    .push_o  (push),
    .word_o  (push_word)
  );

  tx_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .pop_i    (pop_i),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .count_o  (count_o),
    .empty_o  (empty),
    .full_o   (full)
  );

  tx_word_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (push),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (push_word),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (word_o)
  );

  assign ready_o = empty;
  assign full_o  = full;
endmodule

// File: rtl/tx_word_fifo_chk.sv
module tx_word_fifo_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ld_lo_i,
  input logic             ld_hi_i,
  input logic             pop_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ready_o,
  input logic             full_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH)); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && full_o)); // R8
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> $stable(count_o)); // R7
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && pop_i && !ld_hi_i) |=> (count_o == '0)); // R9
  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && pop_i && !ld_hi_i) |=> (count_o == $past(count_o) - 1'b1)); // R5
  AST_LO_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo_i && !ld_hi_i && !pop_i) |=> $stable(count_o)); // R2
endmodule

bind tx_word_fifo tx_word_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ld_lo_i (ld_lo_i),
  .ld_hi_i (ld_hi_i),
  .pop_i   (pop_i),
  .count_o (count_o),
  .ready_o (ready_o),
  .full_o  (full_o)
);

// File: tb/tx_word_fifo_test.sv
`timescale 1ns/1ps
module tx_word_fifo_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bus = '0;
  logic        ld_lo = 1'b0, ld_hi = 1'b0, pop = 1'b0;
  logic [30:0] word;
  logic [3:0]  count;
  logic        ready, full;

  int n_run = 0, n_fail = 0;
  logic [30:0] sb_q [$];

  always #2.5 clk = ~clk;

  tx_word_fifo uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_i(bus), .ld_lo_i(ld_lo), .ld_hi_i(ld_hi),
    .pop_i(pop), .word_o(word), .count_o(count), .ready_o(ready), .full_o(full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, 32'(count), 32'(sb_q.size()));
    chk(req, 32'(ready), 32'(sb_q.size() == 0));
    chk(req, 32'(full), 32'(sb_q.size() == 8));
  endtask

  task automatic lo_only(input logic [15:0] v);
    @(negedge clk); ld_lo = 1'b1; bus = v;
    @(negedge clk); ld_lo = 1'b0;
  endtask

  task automatic hi_only(input logic [15:0] v, input logic expect_push, input logic [15:0] lo);
    @(negedge clk); ld_hi = 1'b1; bus = v;
    @(negedge clk); ld_hi = 1'b0;
    if (expect_push) sb_q.push_back({v[14:0], lo});
  endtask

  // driver: push one word, model the drop when full
  task automatic push_word(input logic [15:0] lo, input logic [15:0] hi);
    logic room;
    room = (sb_q.size() < 8);
    lo_only(lo);
    hi_only(hi, room, lo);
  endtask

  // monitor: compare head and take it
  task automatic pop_check(input string req);
    @(negedge clk);
    if (sb_q.size() != 0) chk(req, 32'(word), 32'(sb_q[0]));
    pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    if (sb_q.size() != 0) void'(sb_q.pop_front());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_state("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_state("R1 after reset");

    hi_only(16'h1234, 1'b0, '0);
    chk_state("R4 hi without pending");

    lo_only(16'hBEEF);
    chk_state("R2 lo only keeps count");
    hi_only(16'hFFFF, 1'b1, 16'hBEEF);
    chk_state("R3 word committed");
    chk("R3 bit15 dropped", 32'(word), 32'({15'h7FFF, 16'hBEEF}));

    for (int i = 1; i < 8; i++) push_word(16'(i * 16'h1111), 16'(16'h0100 + i));
    chk_state("R6 full at eight");

    push_word(16'hDEAD, 16'h7ABC);
    chk_state("R7 push dropped when full");
    lo_only(16'hCAFE);
    pop_check("R5 head while full");
    chk_state("R7 count after pop");
    hi_only(16'h0042, 1'b0, '0);
    chk_state("R7 lo while full left nothing pending");

    while (sb_q.size() != 0) pop_check("R5 order");
    chk_state("R8 empty after drain");

    pop_check("R9 pop empty");
    chk_state("R9 count stays zero");

    push_word(16'h0A0A, 16'h0001);
    push_word(16'h0B0B, 16'h0002);
    lo_only(16'h0C0C);
    @(negedge clk);
    chk("R10 head before swap", 32'(word), 32'(sb_q[0]));
    ld_hi = 1'b1; bus = 16'h0003; pop = 1'b1;
    @(negedge clk); ld_hi = 1'b0; pop = 1'b0;
    void'(sb_q.pop_front());
    sb_q.push_back({15'h0003, 16'h0C0C});
    chk_state("R10 count unchanged");

    lo_only(16'h1111);
    lo_only(16'h2222);
    hi_only(16'h0055, 1'b1, 16'h2222);
    chk_state("R11 one word added");
    while (sb_q.size() != 0) pop_check("R11 R10 order");

    push_word(16'h3333, 16'h0004);
    lo_only(16'h4444);
    @(negedge clk); rst_ni = 1'b0;
    #1;
    sb_q.delete();
    chk_state("R1 async reset clears");
    @(negedge clk); rst_ni = 1'b1;
    hi_only(16'h0066, 1'b0, '0);
    chk_state("R1 pending half discarded");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule